// File: doc/BRIEF.md
# Board Reset and Enable Sequencer

This controller sits in the board FPGA of a network switch card and takes the card from power-up to a running state in a fixed order. It switches on the power-module rails one after another, checking each rail's power-good. It then releases the switch-chip reset, then the host-processor reset. The PHY group stays in reset until the processor reports that it has finished setting up the switch chip. This keeps the PHYs from driving serial-link traffic into a switch whose serial side is still being configured. When the PHYs come out of reset, the optical transceiver transmit enables are driven to their active level.

A rail that never reports good within a timeout sends the sequencer to a fault state with every rail switched off. A handshake that never arrives sends the devices back into reset and the release order starts again. A flag records that retry. Loss of board power-good forces every output to its safe level at once. A free-running heartbeat toggles throughout as a sign of live logic. All inputs are taken as synchronous to `clk_i`. Every control output is registered, so each one changes one clock after the edge that decides it.

Top module: `brd_bringup_seq`

## Requirements
- R1: While `rst_ni` is low, or `board_pg_i` is low, every `rail_en_no` bit is 1 (off), `sw_rst_no`, `cpu_rst_no` and all `phy_rst_no` are 0 (in reset), and `opt_tx_en_o`, `pwr_fault_o` and `hs_retry_o` are 0.
- R2: Rails are enabled one at a time from index 0 upward. Rail k+1 is enabled (driven 0) one clock after the edge at which `rail_pg_i[k]` is sampled high, and the set of enabled rails is always a contiguous run starting at index 0.
- R3: If the rail currently being brought up does not report good within `PG_TIMEOUT` cycles, `pwr_fault_o` goes to 1 and every rail is switched off. This state holds until `board_pg_i` falls.
- R4: After the last rail reports good, all device resets stay asserted for `HOLD_CYC` cycles. The switch reset is then released first.
- R5: The processor reset is released `HOLD_CYC` cycles after the switch reset, and never before it.
- R6: The PHY resets are released, and `opt_tx_en_o` driven to 1 in the same cycle, only after `sw_init_done_i` has been sampled high. That sample must fall at least `HOLD_CYC - 1` cycles after the processor release step began. An early handshake is held off until then.
- R7: If no handshake arrives within `HS_TIMEOUT` cycles of the processor release step, the switch and processor resets are asserted again and the release order restarts from the hold step. `hs_retry_o` goes to 1 and stays at 1 until `board_pg_i` falls.
- R8: When `board_pg_i` is sampled low in any state, all outputs reach the R1 levels one clock later, and `hs_retry_o` and `pwr_fault_o` clear. When the board supply returns, the sequence restarts from rail 0.
- R9: `hb_o` toggles every `HB_DIV` clock cycles, counted from reset, regardless of the sequencer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| board_pg_i | input | 1 | Board-level power good |
| rail_pg_i | input | N_RAILS | Per-rail power-good feedback |
| sw_init_done_i | input | 1 | Processor reports switch setup finished |
| rail_en_no | output | N_RAILS | Active-low power-module enables |
| sw_rst_no | output | 1 | Switch-chip reset, active low |
| cpu_rst_no | output | 1 | Host-processor reset, active low |
| phy_rst_no | output | N_PHY | PHY resets, active low |
| opt_tx_en_o | output | N_OPT | Optical transceiver transmit enables, active high |
| hb_o | output | 1 | Heartbeat indicator |
| pwr_fault_o | output | 1 | Rail power-good timeout fault |
| hs_retry_o | output | 1 | Handshake timeout caused a reset retry |

## Verification
Two events can coincide: the processor handshake that releases the PHYs, and the loss of board power-good that must force everything safe. The bench drives `sw_init_done_i` high and `board_pg_i` low on the same falling edge. It does so after the processor hold has elapsed, so the handshake alone would be accepted. The check is that the PHY resets and transmit enables never leave their safe level and that every reset is asserted on the next cycle. The handshake timeout racing a late handshake is handled the same way. The cycle-level model in the bench decides every one of these cases, and the outputs are compared against it on every clock.

// File: rtl/brd_seq_pkg.sv
package brd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_FAULT,
    ST_HOLD,
    ST_SW_REL,
    ST_CPU_WAIT,
    ST_RUN
  } seq_state_e;
endpackage

// File: rtl/brd_seq_fsm.sv
module brd_seq_fsm
  import brd_seq_pkg::*;
#(
  parameter int N_RAILS    = 4,
  parameter int PG_TIMEOUT = 1_250_000,
  parameter int HOLD_CYC   = 12_500,
  parameter int HS_TIMEOUT = 250_000_000,
  parameter int IDX_W      = 2,
  parameter int CNT_W      = 28
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               board_pg_i,
  input  logic [N_RAILS-1:0] rail_pg_i,
  input  logic               sw_init_done_i,
  output seq_state_e         state_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               retry_o
);
  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             retry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      retry_q <= 1'b0;
    end else if (!board_pg_i) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      retry_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_PWR;
          idx_q   <= '0;
          cnt_q   <= '0;
        end
        ST_PWR: begin
          if (rail_pg_i[idx_q]) begin
            cnt_q <= '0;
            if (idx_q == IDX_W'(N_RAILS - 1)) state_q <= ST_HOLD;
            else                               idx_q   <= idx_q + IDX_W'(1);
          end else if (cnt_q == CNT_W'(PG_TIMEOUT - 1)) begin
            state_q <= ST_FAULT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_FAULT: state_q <= ST_FAULT;
        ST_HOLD, ST_SW_REL: begin
          if (cnt_q == CNT_W'(HOLD_CYC - 1)) begin
            cnt_q   <= '0;
            state_q <= (state_q == ST_HOLD) ? ST_SW_REL : ST_CPU_WAIT;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_CPU_WAIT: begin
          // handshake accepted only once the processor hold has elapsed
          if (sw_init_done_i && cnt_q >= CNT_W'(HOLD_CYC - 1)) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
          end else if (cnt_q == CNT_W'(HS_TIMEOUT - 1)) begin
            state_q <= ST_HOLD;
            retry_q <= 1'b1;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_RUN:  state_q <= ST_RUN;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;
  assign retry_o = retry_q;
endmodule

// File: rtl/brd_seq_outreg.sv
module brd_seq_outreg
  import brd_seq_pkg::*;
#(
  parameter int N_RAILS = 4,
  parameter int N_PHY   = 4,
  parameter int N_OPT   = 4,
  parameter int IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               board_pg_i,
  input  seq_state_e         state_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               retry_i,
  output logic [N_RAILS-1:0] rail_en_no,
  output logic               sw_rst_no,
  output logic               cpu_rst_no,
  output logic [N_PHY-1:0]   phy_rst_no,
  output logic [N_OPT-1:0]   opt_tx_en_o,
  output logic               pwr_fault_o,
  output logic               hs_retry_o
);
  logic [N_RAILS-1:0] rail_on;
  logic               all_on, sw_rel, cpu_rel, phy_rel;

  assign all_on  = state_i inside {ST_HOLD, ST_SW_REL, ST_CPU_WAIT, ST_RUN};
  assign sw_rel  = state_i inside {ST_SW_REL, ST_CPU_WAIT, ST_RUN};
  assign cpu_rel = state_i inside {ST_CPU_WAIT, ST_RUN};
  assign phy_rel = (state_i == ST_RUN);

  for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
    assign rail_on[g] = (state_i == ST_PWR) ? (IDX_W'(g) <= idx_i) : all_on;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rail_en_no  <= '1;
      sw_rst_no   <= 1'b0;
      cpu_rst_no  <= 1'b0;
      phy_rst_no  <= '0;
      opt_tx_en_o <= '0;
      pwr_fault_o <= 1'b0;
      hs_retry_o  <= 1'b0;
    end else begin
      rail_en_no  <= board_pg_i ? ~rail_on : '1;
      sw_rst_no   <= board_pg_i & sw_rel;
      cpu_rst_no  <= board_pg_i & cpu_rel;
      phy_rst_no  <= {N_PHY{board_pg_i & phy_rel}};
      opt_tx_en_o <= {N_OPT{board_pg_i & phy_rel}};
      pwr_fault_o <= board_pg_i & (state_i == ST_FAULT);
      hs_retry_o  <= board_pg_i & retry_i;
    end
  end
endmodule

// File: rtl/brd_seq_hb.sv
module brd_seq_hb #(
  parameter int HB_DIV = 62_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hb_o
);
  localparam int W = (HB_DIV > 1) ? $clog2(HB_DIV) : 1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      hb_o  <= 1'b0;
    end else if (cnt_q == W'(HB_DIV - 1)) begin
      cnt_q <= '0;
      hb_o  <= ~hb_o;
    end else begin
      cnt_q <= cnt_q + W'(1);
    end
  end
endmodule

// File: rtl/brd_bringup_seq.sv
module brd_bringup_seq
  import brd_seq_pkg::*;
#(
  parameter int N_RAILS    = 4,
  parameter int N_PHY      = 4,
  parameter int N_OPT      = 4,
  parameter int PG_TIMEOUT = 1_250_000,
  parameter int HOLD_CYC   = 12_500,
  parameter int HS_TIMEOUT = 250_000_000,
  parameter int HB_DIV     = 62_500_000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               board_pg_i,
  input  logic [N_RAILS-1:0] rail_pg_i,
  input  logic               sw_init_done_i,
  output logic [N_RAILS-1:0] rail_en_no,
  output logic               sw_rst_no,
  output logic               cpu_rst_no,
  output logic [N_PHY-1:0]   phy_rst_no,
  output logic [N_OPT-1:0]   opt_tx_en_o,
  output logic               hb_o,
  output logic               pwr_fault_o,
  output logic               hs_retry_o
);
  localparam int IDX_W   = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam int MAX_A   = (PG_TIMEOUT > HS_TIMEOUT) ? PG_TIMEOUT : HS_TIMEOUT;
  localparam int CNT_MAX = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       state;
  logic [IDX_W-1:0] idx;
  logic             retry;

  brd_seq_fsm #(
    .N_RAILS(N_RAILS), .PG_TIMEOUT(PG_TIMEOUT), .HOLD_CYC(HOLD_CYC),
    .HS_TIMEOUT(HS_TIMEOUT), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk_i, .rst_ni, .board_pg_i, .rail_pg_i, .sw_init_done_i,
    .state_o(state), .idx_o(idx), .retry_o(retry)
  );

  brd_seq_outreg #(
    .N_RAILS(N_RAILS), .N_PHY(N_PHY), .N_OPT(N_OPT), .IDX_W(IDX_W)
  ) u_out (
    .clk_i, .rst_ni, .board_pg_i,
    .state_i(state), .idx_i(idx), .retry_i(retry),
    .rail_en_no, .sw_rst_no, .cpu_rst_no, .phy_rst_no, .opt_tx_en_o,
    .pwr_fault_o, .hs_retry_o
  );

  brd_seq_hb #(.HB_DIV(HB_DIV)) u_hb (.clk_i, .rst_ni, .hb_o);
endmodule

// File: rtl/brd_bringup_seq_chk.sv
module brd_bringup_seq_chk #(
  parameter int N_RAILS = 4,
  parameter int N_PHY   = 4,
  parameter int N_OPT   = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               board_pg_i,
  input logic               sw_init_done_i,
  input logic [N_RAILS-1:0] rail_en_no,
  input logic               sw_rst_no,
  input logic               cpu_rst_no,
  input logic [N_PHY-1:0]   phy_rst_no,
  input logic [N_OPT-1:0]   opt_tx_en_o,
  input logic               pwr_fault_o
);
  logic [N_RAILS-1:0] rail_on;
  assign rail_on = ~rail_en_no;

  // R2
  rail_prefix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rail_on & (rail_on + N_RAILS'(1))) == '0);

  // R3
  fault_rails_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_fault_o |-> (&rail_en_no));

  // R4
  sw_needs_rails_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_no |-> (rail_en_no == '0));

  // R5
  cpu_after_sw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_rst_no |-> sw_rst_no);

  // R6
  phy_after_cpu_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|phy_rst_no) |-> cpu_rst_no);

  // R6
  phy_on_handshake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(&phy_rst_no) |-> $past(sw_init_done_i));

  // R6
  opt_with_phy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|opt_tx_en_o) |-> (&phy_rst_no));

  // R8
  pg_loss_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !board_pg_i |=> (!sw_rst_no && !cpu_rst_no && phy_rst_no == '0 &&
                     opt_tx_en_o == '0 && (&rail_en_no) && !pwr_fault_o));
endmodule

bind brd_bringup_seq brd_bringup_seq_chk #(
  .N_RAILS(N_RAILS), .N_PHY(N_PHY), .N_OPT(N_OPT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .board_pg_i(board_pg_i),
  .sw_init_done_i(sw_init_done_i), .rail_en_no(rail_en_no),
  .sw_rst_no(sw_rst_no), .cpu_rst_no(cpu_rst_no), .phy_rst_no(phy_rst_no),
  .opt_tx_en_o(opt_tx_en_o), .pwr_fault_o(pwr_fault_o)
);

// File: tb/brd_bringup_seq_tb.sv
module brd_bringup_seq_tb;
  localparam int NR = 4, NP = 3, NO = 2;
  localparam int PG_TO = 20, HOLD = 5, HS_TO = 40, HB = 7;
  localparam int M_IDLE = 0, M_PWR = 1, M_FAULT = 2, M_HOLD = 3,
                 M_SWREL = 4, M_CPUW = 5, M_RUN = 6;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          board_pg = 1'b0;
  logic [NR-1:0] rail_pg = '0;
  logic          init_done = 1'b0;
  logic [NR-1:0] rail_en_no;
  logic          sw_rst_no, cpu_rst_no, hb_o, pwr_fault_o, hs_retry_o;
  logic [NP-1:0] phy_rst_no;
  logic [NO-1:0] opt_tx_en_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  brd_bringup_seq #(
    .N_RAILS(NR), .N_PHY(NP), .N_OPT(NO), .PG_TIMEOUT(PG_TO),
    .HOLD_CYC(HOLD), .HS_TIMEOUT(HS_TO), .HB_DIV(HB)
  ) u_dut (
    .clk_i(clk), .rst_ni, .board_pg_i(board_pg), .rail_pg_i(rail_pg),
    .sw_init_done_i(init_done), .rail_en_no, .sw_rst_no, .cpu_rst_no,
    .phy_rst_no, .opt_tx_en_o, .hb_o, .pwr_fault_o, .hs_retry_o
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // rail emulation: a rail reports good a fixed number of cycles after enable
  int dly[NR] = '{2, 4, 1, 3};
  bit dead[NR] = '{0, 0, 0, 0};
  int on_cnt[NR] = '{0, 0, 0, 0};
  always @(negedge clk) begin
    for (int i = 0; i < NR; i++) begin
      if (rail_en_no[i]) on_cnt[i] = 0;
      else on_cnt[i] = on_cnt[i] + 1;
      rail_pg[i] <= !dead[i] && on_cnt[i] >= dly[i];
    end
  end

  // reference model
  int m_st, m_idx, m_cnt, m_hcnt;
  bit m_retry;
  logic [NR-1:0] x_en_n;
  logic x_sw, x_cpu, x_phy, x_fault, x_retry, x_hb;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = M_IDLE; m_idx = 0; m_cnt = 0; m_retry = 0; m_hcnt = 0;
      x_en_n = '1; x_sw = 0; x_cpu = 0; x_phy = 0; x_fault = 0; x_retry = 0; x_hb = 0;
    end else begin
      if (m_hcnt == HB - 1) begin m_hcnt = 0; x_hb = !x_hb; end
      else m_hcnt++;
      if (!board_pg) begin
        x_en_n = '1; x_sw = 0; x_cpu = 0; x_phy = 0; x_fault = 0; x_retry = 0;
        m_st = M_IDLE; m_idx = 0; m_cnt = 0; m_retry = 0;
      end else begin
        for (int i = 0; i < NR; i++)
          x_en_n[i] = !((m_st == M_PWR && i <= m_idx) || m_st >= M_HOLD);
        x_sw    = m_st >= M_SWREL;
        x_cpu   = m_st >= M_CPUW;
        x_phy   = m_st == M_RUN;
        x_fault = m_st == M_FAULT;
        x_retry = m_retry;
        case (m_st)
          M_IDLE: begin m_st = M_PWR; m_idx = 0; m_cnt = 0; end
          M_PWR:
            if (rail_pg[m_idx]) begin
              m_cnt = 0;
              if (m_idx == NR - 1) m_st = M_HOLD; else m_idx++;
            end else if (m_cnt == PG_TO - 1) m_st = M_FAULT;
            else m_cnt++;
          M_HOLD, M_SWREL:
            if (m_cnt == HOLD - 1) begin m_cnt = 0; m_st = m_st + 1; end
            else m_cnt++;
          M_CPUW:
            if (init_done && m_cnt >= HOLD - 1) begin m_st = M_RUN; m_cnt = 0; end
            else if (m_cnt == HS_TO - 1) begin m_st = M_HOLD; m_retry = 1; m_cnt = 0; end
            else m_cnt++;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !finished) begin
      chk("R2", "rail_en_no", rail_en_no, x_en_n);
      chk("R4", "sw_rst_no", sw_rst_no, x_sw);
      chk("R5", "cpu_rst_no", cpu_rst_no, x_cpu);
      chk("R6", "phy_rst_no", phy_rst_no, {NP{x_phy}});
      chk("R6", "opt_tx_en_o", opt_tx_en_o, {NO{x_phy}});
      chk("R3", "pwr_fault_o", pwr_fault_o, x_fault);
      chk("R7", "hs_retry_o", hs_retry_o, x_retry);
      chk("R9", "hb_o", hb_o, x_hb);
    end
  end

  task automatic safe_chk(input string tag);
    chk(tag, "rails off", rail_en_no, {NR{1'b1}});
    chk(tag, "sw reset", sw_rst_no, 0);
    chk(tag, "cpu reset", cpu_rst_no, 0);
    chk(tag, "phy reset", phy_rst_no, 0);
    chk(tag, "opt tx", opt_tx_en_o, 0);
    chk(tag, "fault", pwr_fault_o, 0);
    chk(tag, "retry", hs_retry_o, 0);
  endtask

  task automatic wait_cpu();
    for (int k = 0; k < 400 && !cpu_rst_no; k++) @(negedge clk);
  endtask

  task automatic wait_phy();
    for (int k = 0; k < 400 && !phy_rst_no[0]; k++) @(negedge clk);
  endtask

  task automatic drop_pg();
    board_pg = 0; init_done = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    safe_chk("R1");
    rst_ni = 1;
    @(negedge clk);
    safe_chk("R1");

    // normal bring-up, late handshake
    board_pg = 1;
    wait_cpu();
    chk("R5", "cpu released", cpu_rst_no, 1);
    repeat (8) @(negedge clk);
    init_done = 1;
    wait_phy();
    chk("R6", "phy released", phy_rst_no, {NP{1'b1}});
    chk("R6", "opt tx on", opt_tx_en_o, {NO{1'b1}});
    repeat (5) @(negedge clk);

    // plain loss of board power
    board_pg = 0;
    @(negedge clk);
    safe_chk("R8");
    drop_pg();

    // early handshake is held off until the processor hold ends
    init_done = 1; board_pg = 1;
    wait_cpu();
    chk("R6", "phy held on early handshake", phy_rst_no, 0);
    wait_phy();
    chk("R6", "phy released after hold", phy_rst_no, {NP{1'b1}});
    drop_pg();

    // handshake timeout and retry
    board_pg = 1;
    for (int k = 0; k < 600 && !hs_retry_o; k++) @(negedge clk);
    chk("R7", "retry flag", hs_retry_o, 1);
    chk("R7", "cpu re-reset", cpu_rst_no, 0);
    chk("R7", "sw re-reset", sw_rst_no, 0);
    init_done = 1;
    wait_phy();
    chk("R7", "run after retry", phy_rst_no, {NP{1'b1}});
    chk("R7", "retry sticky", hs_retry_o, 1);
    board_pg = 0;
    @(negedge clk);
    safe_chk("R8");
    drop_pg();

    // handshake and power loss on the same edge
    board_pg = 1;
    wait_cpu();
    repeat (HOLD + 2) @(negedge clk);
    init_done = 1; board_pg = 0;
    @(negedge clk);
    safe_chk("R8");
    @(negedge clk);
    chk("R8", "phy stays in reset", phy_rst_no, 0);
    drop_pg();

    // dead rail leads to fault
    dead[2] = 1;
    board_pg = 1;
    for (int k = 0; k < 300 && !pwr_fault_o; k++) @(negedge clk);
    chk("R3", "fault raised", pwr_fault_o, 1);
    chk("R3", "rails off in fault", rail_en_no, {NR{1'b1}});
    repeat (20) @(negedge clk);
    chk("R3", "fault held", pwr_fault_o, 1);
    board_pg = 0;
    @(negedge clk);
    safe_chk("R8");
    dead[2] = 0;
    repeat (2) @(negedge clk);

    // heartbeat period
    begin
      logic h0;
      int per;
      h0 = hb_o;
      for (int k = 0; k < 50 && hb_o == h0; k++) @(negedge clk);
      h0 = hb_o; per = 0;
      for (int k = 0; k < 50 && hb_o == h0; k++) begin @(negedge clk); per++; end
      chk("R9", "heartbeat period", per, HB);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog (whole sequence): actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule